// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-visible register file of an I/O interrupt controller. A 32-bit bus slave shows two registers: a select register that holds an 8-bit index, and a data window through which the indexed register is read or written. Behind the window are an identity register, a read-only version register, an arbitration register that mirrors the identity, and one 64-bit redirection entry per interrupt pin, reached as two 32-bit halves.

The complete entry table is driven out in parallel to the delivery engine. That engine reports, through a per-pin set/clear sideband, when a level-triggered interrupt has been sent (remote-IRR set) or acknowledged (remote-IRR cleared). Whenever a bus write alters the trigger mode, delivery mode or vector of an entry, the block emits a one-cycle request so the trigger-mode tables further on can be rebuilt. Interrupt delivery is not part of this block.

Entry low-half layout: bits 7:0 vector, 10:8 delivery mode, 11 destination mode (1 = logical), 12 delivery status, 13 polarity (1 = active low), 14 remote-IRR, 15 trigger mode (1 = level), 16 mask. The destination sits in bits 63:56.

Top module: `irq_route_regfile`

## Requirements
- R1: Only accesses with `bus_size` = 2 (four bytes) are accepted; any other size code (0 = 1 byte, 1 = 2 bytes, 3 = 8 bytes) gets a response with `bus_err` high, `bus_rdata` of 0, and changes no register.
- R2: A write to byte offset 0x00 stores bits 7:0 of the data as the window index; a read of offset 0x00 returns that index zero-extended to 32 bits.
- R3: Reads of any offset other than 0x00 and 0x10 return 0xFFFFFFFF; writes to those offsets change nothing.
- R4: Through the window (offset 0x10), index 0x00 is the identity register, which keeps only bits 27:24 of written data; index 0x02 reads the same value as index 0x00.
- R5: Index 0x01 reads ((pin count − 1) << 16) | 0x11; writes to index 0x01 and 0x02 change nothing.
- R6: Index 0x10 + 2p addresses bits 31:0 of entry p and index 0x11 + 2p its bits 63:32; a window read of any index that is neither a fixed register nor inside the table returns 0.
- R7: A write to a low half keeps the entry's current bits 14 and 12 and takes all other low bits from the data; a write to a high half replaces all 32 high bits.
- R8: After any cycle in which an entry's bit 15 is 0, its bit 14 is 0; a write that clears bit 15 also clears bit 14.
- R9: After reset every entry is 0x0001_0000_0001_0000 (bits 16 and 48 set), and the identity and index registers are 0.
- R10: `tmr_update` is high for exactly the cycle after a write that changes bit 15, bits 10:8 or bits 7:0 of an entry, and low after any other write or idle cycle.
- R11: `irr_clr[p]` clears bit 14 of entry p at the next clock edge; `irr_set[p]` sets it only when bit 15 is 1 and has no effect on an edge-mode entry; when both are high, clear wins.
- R12: Every request strobe gets `bus_resp` high on the following cycle, with read data registered from the state before that edge; no response appears without a request.
- R13: `entry_table[64p+63:64p]` always carries entry p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | One-cycle request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the request |
| bus_size | input | 2 | Access size code (2 = four bytes) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_resp | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Size error flag, valid with `bus_resp` |
| irr_set | input | N_PINS | Per-pin remote-IRR set from the delivery engine |
| irr_clr | input | N_PINS | Per-pin remote-IRR clear from the delivery engine |
| entry_table | output | 64*N_PINS | All redirection entries, pin 0 in the lowest bits |
| tmr_update | output | 1 | Trigger-mode table rebuild request pulse |

## Verification
A corrupted entry shows up on `entry_table` in the cycle after the bad update, so comparing the whole table after every request catches it with no delay, while a wrong identity or index value only appears when a later read reaches it. A misplaced preserve mask shows as a remote-IRR bit that vanishes or appears across a low-half write, and a wrong change mask shows as a missing or extra `tmr_update` pulse in the response cycle. Random traffic mixes sideband pulses with table writes so that write-versus-sideband ordering within one edge is exercised.

// File: rtl/irq_route_pkg.sv
// Package: shared constants and types of the interrupt redirection window.
// Assumes an 8-bit select register and 64-bit entries split into 32-bit halves.
package irq_route_pkg;

    // Bus size codes; only the four-byte code is accepted.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } bus_size_e;

    // Kind of read a request performs, after decode.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_SEL   = 2'd1,
        ACC_WIN   = 2'd2,
        ACC_OTHER = 2'd3
    } access_e;

    // Window indexes of the fixed registers and of the table base.
    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
    localparam logic [7:0] IDX_TBL = 8'h10;

    // Entry bit positions used by the logic.
    localparam int BIT_DSTAT = 12;
    localparam int BIT_IRR   = 14;
    localparam int BIT_TRIG  = 15;

    // Low-half bits owned by hardware and kept across a bus write.
    localparam logic [31:0] LO_HW_MASK  = (32'd1 << BIT_IRR) | (32'd1 << BIT_DSTAT);
    // Low-half fields whose change asks for a trigger-mode table rebuild.
    localparam logic [31:0] TMR_FIELDS  = (32'd1 << BIT_TRIG) | 32'h0000_07FF;
    // Identity bits kept on write.
    localparam logic [31:0] ID_KEEP     = 32'h0F00_0000;
    // Version code in the low byte of the version register.
    localparam logic [7:0]  VER_CODE    = 8'h11;
    // Reset value of every entry: both mask bits set.
    localparam logic [63:0] ENTRY_RESET = 64'h0001_0000_0001_0000;

endpackage

// File: rtl/irq_route_decode.sv
// Module: bus-side decode for the redirection window.
// Classifies each request strobe, holds the select register and registers
// the response flags. Assumes one request per strobe and no back-pressure.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic [7:0]        sel_q,
    output logic              win_wr,
    output access_e           rd_kind,
    output logic              rsp_valid_q,
    output logic              rsp_err_q
);

    localparam logic [ADDR_W-1:0] OFS_SEL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_WIN = ADDR_W'(8'h10);

    logic    size_ok;
    access_e target;
    logic    sel_wr;

    // Map the request offset to the register it targets.
    always_comb begin
        size_ok = (req_size == SZ_WORD);
        if (req_addr == OFS_SEL)      target = ACC_SEL;
        else if (req_addr == OFS_WIN) target = ACC_WIN;
        else                          target = ACC_OTHER;
        sel_wr  = req_valid && req_write && size_ok && (target == ACC_SEL);
        win_wr  = req_valid && req_write && size_ok && (target == ACC_WIN);
        rd_kind = (req_valid && !req_write && size_ok) ? target : ACC_NONE;
    end

    // Select register: keeps the low byte of the written data.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= req_wdata[7:0];
    end

    // Response strobe and size error, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_err_q   <= req_valid && !size_ok;
        end
    end

    // R1
    bad_size_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != SZ_WORD) |=> $stable(sel_q));

    // R12
    rsp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_q |-> $past(req_valid));

    // R12
    req_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid_q);

endmodule

// File: rtl/irq_route_entry.sv
// Module: one 64-bit redirection entry.
// Applies half writes, keeps the hardware-owned low bits, merges the
// remote-IRR sideband and forces remote-IRR low in edge mode. Flags a
// change of trigger mode, delivery mode or vector. Assumes at most one of
// wr_lo / wr_hi per cycle.
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        irr_set,
    input  logic        irr_clr,
    output logic [63:0] entry_o,
    output logic        chg_o
);

    logic [63:0] entry_q;
    logic [63:0] entry_d;
    logic        irr_d;

    // Next value: half write, then sideband merge, then edge-mode clear.
    always_comb begin
        entry_d = entry_q;
        if (wr_lo) entry_d[31:0]  = (entry_q[31:0] & LO_HW_MASK) | (wdata & ~LO_HW_MASK);
        if (wr_hi) entry_d[63:32] = wdata;
        irr_d = entry_d[BIT_TRIG] && !irr_clr && (entry_d[BIT_IRR] || irr_set);
        entry_d[BIT_IRR] = irr_d;
        chg_o = wr_lo && (|((entry_q[31:0] ^ entry_d[31:0]) & TMR_FIELDS));
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (!rst_n) entry_q <= ENTRY_RESET;
        else        entry_q <= entry_d;
    end

    assign entry_o = entry_q;

    // R8
    edge_irr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_q[BIT_TRIG] |-> !entry_q[BIT_IRR]);

    // R7
    lo_hw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !irr_set && !irr_clr && wdata[BIT_TRIG])
        |=> (entry_q[BIT_IRR] == $past(entry_q[BIT_IRR]))
            && (entry_q[BIT_DSTAT] == $past(entry_q[BIT_DSTAT])));

    // R7
    hi_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (entry_q[63:32] == $past(wdata)));

    // R11
    irr_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irr_clr |=> !entry_q[BIT_IRR]);

endmodule

// File: rtl/irq_route_regfile.sv
// Module: top of the interrupt redirection register window.
// Holds the identity register, the entry array and the read path, and
// raises the trigger-mode rebuild pulse. Assumes 1 <= N_PINS <= 120 so the
// table fits in the 8-bit index space.
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int N_PINS = 24,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_resp,
    output logic                bus_err,
    input  logic [N_PINS-1:0]   irr_set,
    input  logic [N_PINS-1:0]   irr_clr,
    output logic [64*N_PINS-1:0] entry_table,
    output logic                tmr_update
);

    localparam int          TBL_END  = 16 + 2 * N_PINS;
    localparam logic [31:0] VER_WORD = (32'(N_PINS - 1) << 16) | {24'd0, VER_CODE};

    logic [7:0]  sel_q;
    logic        win_wr;
    access_e     rd_kind;
    logic [31:0] id_q;
    logic        tbl_hit;
    logic [7:0]  tbl_off;
    logic [31:0] win_word;
    logic [31:0] rd_word;
    logic [31:0] rdata_q;
    logic        tmr_q;
    logic [N_PINS-1:0] chg;
    logic [63:0] ent [N_PINS];

    irq_route_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (bus_valid),
        .req_write   (bus_write),
        .req_addr    (bus_addr),
        .req_size    (bus_size),
        .req_wdata   (bus_wdata),
        .sel_q       (sel_q),
        .win_wr      (win_wr),
        .rd_kind     (rd_kind),
        .rsp_valid_q (bus_resp),
        .rsp_err_q   (bus_err)
    );

    // Table address decode from the window index.
    always_comb begin
        tbl_hit = (int'(sel_q) >= int'(IDX_TBL)) && (int'(sel_q) < TBL_END);
        tbl_off = sel_q - IDX_TBL;
    end

    // One entry per pin, each with its own half-write enables.
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic hit;
        assign hit = win_wr && tbl_hit && (tbl_off[7:1] == 7'(p));
        irq_route_entry u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (hit && !tbl_off[0]),
            .wr_hi   (hit && tbl_off[0]),
            .wdata   (bus_wdata),
            .irr_set (irr_set[p]),
            .irr_clr (irr_clr[p]),
            .entry_o (ent[p]),
            .chg_o   (chg[p])
        );
        assign entry_table[64*p +: 64] = ent[p];
    end

    // Identity register: keeps only its defined field.
    always_ff @(posedge clk) begin
        if (!rst_n)                         id_q <= '0;
        else if (win_wr && sel_q == IDX_ID) id_q <= bus_wdata & ID_KEEP;
    end

    // Window read mux over fixed registers and table halves.
    always_comb begin
        win_word = '0;
        if (sel_q == IDX_ID || sel_q == IDX_ARB) begin
            win_word = id_q;
        end else if (sel_q == IDX_VER) begin
            win_word = VER_WORD;
        end else if (tbl_hit) begin
            for (int p = 0; p < N_PINS; p++) begin
                if (tbl_off[7:1] == 7'(p)) win_word = tbl_off[0] ? ent[p][63:32] : ent[p][31:0];
            end
        end
    end

    // Bus read mux by request kind.
    always_comb begin
        case (rd_kind)
            ACC_SEL:   rd_word = {24'd0, sel_q};
            ACC_WIN:   rd_word = win_word;
            ACC_OTHER: rd_word = '1;
            default:   rd_word = '0;
        endcase
    end

    // Registered read data and rebuild pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            tmr_q   <= 1'b0;
        end else begin
            rdata_q <= rd_word;
            tmr_q   <= |chg;
        end
    end

    assign bus_rdata  = rdata_q;
    assign tmr_update = tmr_q;

    // R10
    tmr_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_update |-> $past(bus_valid && bus_write));

    // R1
    bad_size_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_size != SZ_WORD) |=> $stable(id_q));

    // R4
    id_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_q & ~ID_KEEP) == 32'd0);

    // R1
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'd0));

endmodule

// File: tb/test_irq_route_regfile.sv
// Bench: directed corner cases then seeded random traffic, checked against
// a reference model held in bench variables.
module test_irq_route_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int PINS       = 24;
    localparam int WD_LIMIT   = 150000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_valid = 1'b0;
    logic                 bus_write = 1'b0;
    logic [7:0]           bus_addr = '0;
    logic [1:0]           bus_size = 2'd2;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 bus_resp;
    logic                 bus_err;
    logic [PINS-1:0]      irr_set = '0;
    logic [PINS-1:0]      irr_clr = '0;
    logic [64*PINS-1:0]   entry_table;
    logic                 tmr_update;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] m_ent [PINS];
    logic [31:0] m_id;
    logic [7:0]  m_sel;

    irq_route_regfile #(.N_PINS(PINS), .ADDR_W(8)) i_irq_route_regfile (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_resp(bus_resp), .bus_err(bus_err),
        .irr_set(irr_set), .irr_clr(irr_clr), .entry_table(entry_table),
        .tmr_update(tmr_update)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WD_LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] win_read(input logic [7:0] idx);
        int p;
        if (idx == 8'h00 || idx == 8'h02) return m_id;
        if (idx == 8'h01) return (32'(PINS - 1) << 16) | 32'h11;
        if (int'(idx) >= 16 && int'(idx) < 16 + 2 * PINS) begin
            p = (int'(idx) - 16) / 2;
            return idx[0] ? m_ent[p][63:32] : m_ent[p][31:0];
        end
        return 32'd0;
    endfunction

    function automatic logic [64*PINS-1:0] model_table();
        logic [64*PINS-1:0] t;
        for (int p = 0; p < PINS; p++) t[64*p +: 64] = m_ent[p];
        return t;
    endfunction

    // One request; called at a falling edge, returns at the next one.
    task automatic do_op(input bit wr, input logic [7:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd, input logic [PINS-1:0] st,
                         input logic [PINS-1:0] cl, input string tag);
        bit          e_err;
        bit          e_tmr;
        logic [31:0] e_rd;
        logic [63:0] old;
        logic [63:0] nw;
        int          p;
        e_err = (sz != 2'd2);
        e_rd  = 32'd0;
        e_tmr = 1'b0;
        if (!wr && !e_err)
            e_rd = (addr == 8'h00) ? {24'd0, m_sel} : (addr == 8'h10) ? win_read(m_sel) : 32'hFFFF_FFFF;
        if (wr && !e_err) begin
            if (addr == 8'h00) begin
                m_sel = wd[7:0];
            end else if (addr == 8'h10) begin
                if (m_sel == 8'h00) begin
                    m_id = wd & 32'h0F00_0000;
                end else if (int'(m_sel) >= 16 && int'(m_sel) < 16 + 2 * PINS) begin
                    p   = (int'(m_sel) - 16) / 2;
                    old = m_ent[p];
                    nw  = old;
                    if (m_sel[0]) nw[63:32] = wd;
                    else          nw[31:0]  = (old[31:0] & 32'h0000_5000) | (wd & ~32'h0000_5000);
                    e_tmr = !m_sel[0] && (|((old[31:0] ^ nw[31:0]) & 32'h0000_87FF));
                    m_ent[p] = nw;
                end
            end
        end
        for (int q = 0; q < PINS; q++)
            m_ent[q][14] = m_ent[q][15] & ~cl[q] & (m_ent[q][14] | st[q]);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_size = sz;
        bus_wdata = wd; irr_set = st; irr_clr = cl;
        @(negedge clk);
        bus_valid = 1'b0; irr_set = '0; irr_clr = '0;
        chk(bus_resp == 1'b1, {"R12 resp ", tag}, 64'(bus_resp), 64'd1);
        chk(bus_err == e_err, {"R1 err ", tag}, 64'(bus_err), 64'(e_err));
        if (!wr) chk(bus_rdata == e_rd, {"rdata ", tag}, 64'(bus_rdata), 64'(e_rd));
        chk(tmr_update == e_tmr, {"R10 tmr ", tag}, 64'(tmr_update), 64'(e_tmr));
        chk(entry_table == model_table(), {"R13 table ", tag}, 64'(entry_table ^ model_table()), 64'd0);
    endtask

    task automatic wsel(input logic [7:0] idx, input string tag);
        do_op(1'b1, 8'h00, 2'd2, {24'hABCDEF, idx}, '0, '0, tag);
    endtask

    task automatic wwin(input logic [31:0] d, input string tag);
        do_op(1'b1, 8'h10, 2'd2, d, '0, '0, tag);
    endtask

    task automatic rwin(input string tag);
        do_op(1'b0, 8'h10, 2'd2, 32'd0, '0, '0, tag);
    endtask

    initial begin
        logic [PINS-1:0] st;
        logic [PINS-1:0] cl;
        int r;
        void'($urandom(32'd4711));
        for (int p = 0; p < PINS; p++) m_ent[p] = 64'h0001_0000_0001_0000;
        m_id = '0;
        m_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state and R12 idle
        chk(entry_table == model_table(), "R9 reset table", 64'(entry_table[63:0]), 64'h0001_0000_0001_0000);
        chk(bus_resp == 1'b0 && tmr_update == 1'b0, "R12 idle", 64'({bus_resp, tmr_update}), 64'd0);
        do_op(1'b0, 8'h00, 2'd2, 32'd0, '0, '0, "R9 select reset");
        rwin("R9 id reset");
        // R2 select keeps low byte
        do_op(1'b1, 8'h00, 2'd2, 32'h1234_56AB, '0, '0, "R2 sel write");
        do_op(1'b0, 8'h00, 2'd2, 32'd0, '0, '0, "R2 sel read");
        // R3 other offsets
        do_op(1'b0, 8'h04, 2'd2, 32'd0, '0, '0, "R3 other read");
        do_op(1'b1, 8'h04, 2'd2, 32'h0000_0000, '0, '0, "R3 other write");
        do_op(1'b0, 8'h00, 2'd2, 32'd0, '0, '0, "R3 sel unchanged");
        // R1 bad sizes
        do_op(1'b1, 8'h00, 2'd0, 32'h0000_0055, '0, '0, "R1 byte write");
        do_op(1'b0, 8'h00, 2'd3, 32'd0, '0, '0, "R1 dword read");
        do_op(1'b0, 8'h00, 2'd2, 32'd0, '0, '0, "R1 sel kept");
        // R4 identity and arbitration
        wsel(8'h00, "R4 sel id");
        wwin(32'hFFFF_FFFF, "R4 id write");
        rwin("R4 id read");
        wsel(8'h02, "R4 sel arb");
        rwin("R4 arb mirror");
        // R5 version read-only, arb write ignored
        wwin(32'h0000_0000, "R5 arb write");
        wsel(8'h01, "R5 sel ver");
        wwin(32'h0000_0000, "R5 ver write");
        rwin("R5 ver read");
        wsel(8'h00, "R5 sel id");
        rwin("R5 id kept");
        // R6 holes
        wsel(8'h05, "R6 sel hole");
        rwin("R6 hole read");
        wsel(8'h40, "R6 sel past end");
        wwin(32'hFFFF_FFFF, "R6 write past end");
        rwin("R6 past end read");
        // R7 R8 R10 R11 on pin 3
        wsel(8'h16, "R7 sel pin3 lo");
        wwin(32'h0000_A031, "R10 level write");
        do_op(1'b0, 8'h10, 2'd2, 32'd0, 24'h000008, '0, "R11 set level");
        wwin(32'h0000_F042, "R7 keep irr");
        wwin(32'hFFFF_F042, "R10 mask only");
        wwin(32'h0000_3042, "R8 edge clears");
        do_op(1'b0, 8'h10, 2'd2, 32'd0, 24'h000008, '0, "R11 set edge ignored");
        wwin(32'h0000_8042, "R10 back to level");
        do_op(1'b0, 8'h10, 2'd2, 32'd0, 24'h000008, 24'h000008, "R11 clear wins");
        do_op(1'b1, 8'h10, 2'd2, 32'h0000_8042, 24'h000008, '0, "R11 write plus set");
        wsel(8'h17, "R7 sel pin3 hi");
        wwin(32'hA500_0000, "R7 hi write");
        rwin("R6 hi read");
        wsel(8'h3F, "R6 sel last hi");
        wwin(32'h1234_5678, "R13 last pin");
        wsel(8'h3E, "R6 sel last lo");
        rwin("R6 last lo read");
        // random phase
        for (int n = 0; n < 4000; n++) begin
            st = '0;
            cl = '0;
            if ($urandom_range(0, 1) == 0) begin
                for (int p = 0; p < PINS; p++) begin
                    st[p] = ($urandom_range(0, 7) == 0);
                    cl[p] = ($urandom_range(0, 15) == 0);
                end
            end
            r = $urandom_range(0, 99);
            if (r < 25) begin
                do_op(1'b1, 8'h00, 2'd2,
                      ($urandom_range(0, 9) == 0) ? $urandom() : 32'(16 + $urandom_range(0, 2*PINS-1)),
                      st, cl, "R7 rnd sel");
            end else if (r < 65) begin
                do_op(1'b1, 8'h10, 2'd2, $urandom(), st, cl, "R8 rnd write");
            end else if (r < 90) begin
                do_op(1'b0, 8'h10, 2'd2, 32'd0, st, cl, "R6 rnd read");
            end else if (r < 95) begin
                do_op($urandom_range(0, 1) == 1, 8'h10, 2'($urandom_range(0, 1) * 3), $urandom(), st, cl, "R1 rnd size");
            end else begin
                do_op($urandom_range(0, 1) == 1, 8'($urandom_range(1, 15) * 16 + 4), 2'd2, $urandom(), st, cl, "R3 rnd other");
            end
        end
        @(negedge clk);
        chk(bus_resp == 1'b0 && tmr_update == 1'b0, "R12 final idle", 64'({bus_resp, tmr_update}), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule